// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector load or store command into a stream of per-element memory addresses. A single-cycle start pulse captures the command: addressing mode, base address, byte stride, element count and a per-element enable mask. From the next cycle on, the block walks the elements in ascending order. Enabled elements are offered one per cycle on a valid/ready handshake, each with its target bank. Disabled elements are stepped over without a memory access.

Memory is modelled as power-of-two interleaved banks of 8-byte words. A bank stays occupied for a fixed number of cycles after each access. If the bank of the element at the head of the stream is still occupied, the stream waits, so a stride that keeps hitting one bank runs at one element per occupancy period. A fourth mode uses the same walk to produce the sequence 0, m, 2m, … for writing into a vector register; this mode ignores banks but still honours the mask. Another engine supplies the index values for indexed mode through `idx_i`, keyed by `elem_o`.

Top module: `vec_agu`

## Requirements
- R1: In mode 0 (unit), element e carries address base + 8·e.
- R2: In mode 1 (strided), element e carries address base + e·stride, where stride is in bytes and the sum wraps modulo 2^AW.
- R3: In mode 2 (indexed), element e carries address base + `idx_i`, with `idx_i` taken while `elem_o` equals e.
- R4: In mode 3 (index sequence), element e carries the value e·stride on `addr_o`. This mode neither occupies nor waits for any bank.
- R5: An element whose mask bit (bit e of `mask_i`) is 0 is never offered on `valid_o` and takes exactly one cycle to step over.
- R6: Elements are processed in ascending order starting the cycle after start. The number processed is `vlen_i`, with values above 64 treated as 64.
- R7: `bank_o` equals the word address modulo 16, which is `addr_o[6:3]` at default parameters.
- R8: In modes 0 to 2, after an access to bank b is accepted in cycle t, no access to b is offered before cycle t+LAT (LAT = 4). The stream waits at the head element until that bank frees, then offers it in the first free cycle.
- R9: While `valid_o` is high and `ready_i` is low, `valid_o`, `addr_o` and `elem_o` hold.
- R10: `done_o` is a one-cycle pulse in the cycle after the last element is accepted or stepped over. With a count of 0, it pulses in the cycle after start.
- R11: A start pulse arriving while `busy_o` is high is ignored and does not disturb the stream in progress.
- R12: After reset, `valid_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture a new command |
| mode_i | input | 2 | 0 unit, 1 strided, 2 indexed, 3 index sequence |
| base_i | input | AW | Base byte address |
| stride_i | input | AW | Byte stride (modes 1 and 3) |
| vlen_i | input | 7 | Element count, clamped to 64 |
| mask_i | input | 64 | Per-element enable |
| idx_i | input | AW | Byte offset for the current element in indexed mode |
| ready_i | input | 1 | Consumer accepts the offered element |
| valid_o | output | 1 | An element address is offered |
| addr_o | output | AW | Element address or sequence value |
| bank_o | output | 4 | Target bank of `addr_o` |
| elem_o | output | 6 | Number of the current element |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | Command finished |

## Verification
Corruption of the element counter or the address accumulator appears on `addr_o` or `elem_o` at the very next offered element. A stuck or early-clearing bank occupancy timer shifts the cycle in which a conflicting element appears, by at least one cycle. The bench therefore compares the exact acceptance cycle of every element against an arithmetic model of bank release, mask skips and backpressure. An off-by-one in end detection moves or removes the `done_o` pulse relative to the last acceptance.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_IOTA   = 2'd3
  } vagu_mode_e;

  localparam int unsigned ELEM_BYTES = 8;
  localparam int unsigned ELEM_SHIFT = $clog2(ELEM_BYTES);
endpackage

// File: rtl/vagu_addr_calc.sv
module vagu_addr_calc
  import vagu_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned NB = 16,
  localparam int unsigned BW = $clog2(NB)
) (
  input  vagu_mode_e    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] acc_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] bank_o
);
  always_comb begin
    unique case (mode_i)
      MODE_INDEX: addr_o = base_i + idx_i;
      MODE_IOTA:  addr_o = acc_i;
      default:    addr_o = base_i + acc_i;
    endcase
  end

  // banks interleave on element words
  assign bank_o = addr_o[ELEM_SHIFT +: BW];
endmodule

// File: rtl/vagu_bank_busy.sv
module vagu_bank_busy #(
  parameter int unsigned NB  = 16,
  parameter int unsigned LAT = 4,
  localparam int unsigned BW = $clog2(NB),
  localparam int unsigned CW = $clog2(LAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic [BW-1:0] bank_i,
  output logic          busy_o
);
  logic [NB-1:0] busy_vec;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cnt_q <= '0;
      else if (hit_i && bank_i == BW'(b))       cnt_q <= CW'(LAT - 1);
      else if (cnt_q != '0)                     cnt_q <= cnt_q - CW'(1);
    end
    assign busy_vec[b] = (cnt_q != '0);
  end

  assign busy_o = busy_vec[bank_i];
endmodule

// File: rtl/vec_agu.sv
module vec_agu
  import vagu_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned NB     = 16,
  parameter int unsigned LAT    = 4,
  localparam int unsigned LW = $clog2(MAX_VL + 1),
  localparam int unsigned EW = $clog2(MAX_VL),
  localparam int unsigned BW = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     stride_i,
  input  logic [LW-1:0]     vlen_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic [AW-1:0]     idx_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [AW-1:0]     addr_o,
  output logic [BW-1:0]     bank_o,
  output logic [EW-1:0]     elem_o,
  output logic              busy_o,
  output logic              done_o
);
  vagu_mode_e        mode_q;
  logic [AW-1:0]     base_q, stride_q, acc_q, step;
  logic [LW-1:0]     vl_q, elem_q, vl_clamp;
  logic [MAX_VL-1:0] mask_q;
  logic              active_q, done_q;
  logic              cur_en, iota, bank_busy, stall, fire, advance, last, accept;

  assign iota     = (mode_q == MODE_IOTA);
  assign cur_en   = mask_q[elem_q[EW-1:0]];
  assign stall    = !iota && bank_busy;
  assign valid_o  = active_q && cur_en && !stall;
  assign fire     = valid_o && ready_i;
  assign advance  = active_q && (!cur_en || fire);
  assign last     = (elem_q == vl_q - LW'(1));
  assign accept   = start_i && !active_q;
  assign step     = (mode_q == MODE_UNIT) ? AW'(ELEM_BYTES) : stride_q;
  assign vl_clamp = (vlen_i > LW'(MAX_VL)) ? LW'(MAX_VL) : vlen_i;

  vagu_addr_calc #(.AW(AW), .NB(NB)) calc_i (
    .mode_i (mode_q),
    .base_i (base_q),
    .acc_i  (acc_q),
    .idx_i  (idx_i),
    .addr_o (addr_o),
    .bank_o (bank_o)
  );

  vagu_bank_busy #(.NB(NB), .LAT(LAT)) banks_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (fire && !iota),
    .bank_i (bank_o),
    .busy_o (bank_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_UNIT;
      base_q   <= '0;
      stride_q <= '0;
      acc_q    <= '0;
      vl_q     <= '0;
      elem_q   <= '0;
      mask_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        mode_q   <= vagu_mode_e'(mode_i);
        base_q   <= base_i;
        stride_q <= stride_i;
        vl_q     <= vl_clamp;
        mask_q   <= mask_i;
        acc_q    <= '0;
        elem_q   <= '0;
        active_q <= (vl_clamp != '0);
        done_q   <= (vl_clamp == '0);
      end else if (advance) begin
        elem_q <= elem_q + LW'(1);
        acc_q  <= acc_q + step;
        if (last) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign elem_o = elem_q[EW-1:0];
  assign busy_o = active_q;
  assign done_o = done_q;
endmodule

// File: rtl/vec_agu_chk.sv
module vec_agu_chk #(
  parameter int unsigned AW  = 32,
  parameter int unsigned EW  = 6,
  parameter int unsigned BW  = 4,
  parameter int unsigned LAT = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_o,
  input logic          ready_i,
  input logic [AW-1:0] addr_o,
  input logic [BW-1:0] bank_o,
  input logic [EW-1:0] elem_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          iota_i
);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(elem_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !valid_o);

  // R6
  valid_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> busy_o);

  if (LAT > 1) begin : g_gap
    // R8
    bank_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && ready_i && !iota_i |=>
        !(valid_o && ready_i && !iota_i && bank_o == $past(bank_o)));
  end
endmodule

bind vec_agu vec_agu_chk #(.AW(AW), .EW(EW), .BW(BW), .LAT(LAT)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_o (valid_o),
  .ready_i (ready_i),
  .addr_o  (addr_o),
  .bank_o  (bank_o),
  .elem_o  (elem_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .iota_i  (iota)
);

// File: tb/vec_agu_tb_top.sv
`timescale 1ns/1ps
module vec_agu_tb_top;
  localparam int LAT = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] base_i = '0, stride_i = '0, idx_i;
  logic [6:0]  vlen_i = '0;
  logic [63:0] mask_i = '0;
  logic        ready_i = 1'b0;
  logic        valid_o, busy_o, done_o;
  logic [31:0] addr_o;
  logic [3:0]  bank_o;
  logic [5:0]  elem_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk_i = ~clk_i;

  // index source: offset depends on current element
  assign idx_i = 32'(elem_o) * 32'd40 + 32'h100;

  vec_agu #(.AW(32), .MAX_VL(64), .NB(16), .LAT(LAT)) dut_i (
    .clk_i, .rst_ni, .start_i, .mode_i, .base_i, .stride_i, .vlen_i, .mask_i,
    .idx_i, .ready_i, .valid_o, .addr_o, .bank_o, .elem_o, .busy_o, .done_o
  );

  function automatic bit rdy(input bit bp, input int t);
    return bp ? ((t % 3) != 1) : 1'b1;
  endfunction

  int          rec_t[64], rec_e[64];
  logic [31:0] rec_a[64];
  logic [3:0]  rec_b[64];

  task automatic run_case(input logic [1:0] md, input logic [31:0] base,
                          input logic [31:0] stride, input int vl,
                          input logic [63:0] mask, input bit bp, input bit poke);
    int n_rec = 0, t = 0, t_done = -1;
    int n_exp = 0, tm = 0, vle, bad = -1;
    int          ex_t[64], ex_e[64];
    logic [31:0] ex_a[64];
    int          freeb[16];
    // model
    vle = (vl > 64) ? 64 : vl;
    for (int b = 0; b < 16; b++) freeb[b] = 0;
    for (int e = 0; e < vle; e++) begin
      if (!mask[e]) tm++;
      else begin
        logic [31:0] a;
        int tt, bk;
        case (md)
          2'd0: a = base + 32'(e) * 32'd8;
          2'd1: a = base + 32'(e) * stride;
          2'd2: a = base + 32'(e) * 32'd40 + 32'h100;
          default: a = 32'(e) * stride;
        endcase
        bk = int'(a[6:3]);
        tt = tm;
        if (md != 2'd3 && tt < freeb[bk]) tt = freeb[bk];
        while (!rdy(bp, tt)) tt++;
        if (md != 2'd3) freeb[bk] = tt + LAT;
        ex_t[n_exp] = tt; ex_e[n_exp] = e; ex_a[n_exp] = a;
        n_exp++;
        tm = tt + 1;
      end
    end
    // stimulus
    @(negedge clk_i);
    start_i = 1'b1; mode_i = md; base_i = base; stride_i = stride;
    vlen_i = 7'(vl); mask_i = mask;
    @(negedge clk_i);
    start_i = 1'b0;
    while (t < 3000) begin
      ready_i = rdy(bp, t);
      if (poke && t == 2) begin
        start_i = 1'b1; mode_i = 2'd3; vlen_i = 7'd5; base_i = 32'hFFFF_0000;
      end else start_i = 1'b0;
      #1;
      if (valid_o && ready_i && n_rec < 64) begin
        rec_t[n_rec] = t; rec_e[n_rec] = int'(elem_o);
        rec_a[n_rec] = addr_o; rec_b[n_rec] = bank_o;
        n_rec++;
      end
      if (done_o) begin t_done = t; break; end
      @(negedge clk_i);
      t++;
    end
    start_i = 1'b0;
    ready_i = 1'b0;
    // R5 R6 count
    n_tests++;
    if (n_rec != n_exp) begin
      n_fail++;
      $display("FAIL R5/R6 mode %0d vl %0d: issued %0d expected %0d", md, vl, n_rec, n_exp);
    end
    // R1 R2 R3 R4 R7 R8 sequence and timing
    n_tests++;
    for (int k = 0; k < n_rec && k < n_exp; k++)
      if (bad < 0 && (rec_t[k] != ex_t[k] || rec_e[k] != ex_e[k] || rec_a[k] != ex_a[k] ||
          (md != 2'd3 && rec_b[k] != ex_a[k][6:3]))) bad = k;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL R1-4/R7/R8 mode %0d item %0d: t %0d e %0d a %h b %0d expected t %0d e %0d a %h b %0d",
               md, bad, rec_t[bad], rec_e[bad], rec_a[bad], rec_b[bad],
               ex_t[bad], ex_e[bad], ex_a[bad], ex_a[bad][6:3]);
    end
    // R10 done timing (R11 when poked)
    n_tests++;
    if (t_done != tm) begin
      n_fail++;
      $display("FAIL R10%s mode %0d vl %0d: done at %0d expected %0d",
               poke ? "/R11" : "", md, vl, t_done, tm);
    end
    repeat (LAT + 1) @(negedge clk_i);
  endtask

  initial begin
    logic [31:0] strides[4];
    logic [63:0] masks[4];
    int          vls[4];
    strides = '{32'd8, 32'd64, 32'd256, 32'd24};
    masks   = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA,
                64'h0F0F_3C3C_9669_F00F, 64'h0};
    vls     = '{1, 7, 64, 100};
    repeat (3) @(negedge clk_i);
    // R12
    n_tests++;
    if (valid_o || busy_o || done_o) begin
      n_fail++;
      $display("FAIL R12: valid %b busy %b done %b expected 0 0 0", valid_o, busy_o, done_o);
    end
    rst_ni = 1'b1;
    for (int md = 0; md < 4; md++) begin
      run_case(2'(md), 32'h1000, 32'd16, 0, '1, 1'b0, 1'b0);
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 4; v++)
          for (int m = 0; m < 4; m++)
            run_case(2'(md), 32'h0004_0000 + 32'(s * 8), strides[s], vls[v], masks[m],
                     bit'((s + v + m) & 1), 1'b0);
    end
    // R2 wrap, R8 single-bank stride, R11 start while busy
    run_case(2'd1, 32'hFFFF_FF00, 32'd128, 64, '1, 1'b0, 1'b0);
    run_case(2'd1, 32'h0, 32'd128, 20, '1, 1'b1, 1'b0);
    run_case(2'd0, 32'h200, 32'd0, 64, '1, 1'b0, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #900000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run incomplete, expected end of sequence");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule